// File: doc/BRIEF.md
# Parallel Slave Port with Handshake Flags

This block lets an external bus master exchange bytes with a local CPU. The master drives three active-low control pins (chip select, write strobe, read strobe). It writes a byte into an input latch and reads a byte from an output latch. The CPU reads the input latch and fills the output latch through a two-address register interface. A control/status byte holds the handshake flags, the port mode and three pin-direction bits.

The control pins are asynchronous to the core clock. They pass through a synchroniser, and transfers are recognised on the rising edge of a strobe. The input-full flag is raised by the master and lowered by the CPU. The output-full flag is raised by the CPU and lowered by the master. A sticky overflow flag records a master write that lands on an unread byte. A one-cycle interrupt pulse marks every completed external transfer. The drive enable for the external data bus comes straight from the pins and is gated by the port mode.

Top module: `psp_port`

## Requirements
- R1: The status byte is {input_full, output_full, overflow, mode, 1, dir[2:0]}, from bit 7 down to bit 0. After reset it reads 8'h0F: all flags and the mode are 0, and all direction bits are 1.
- R2: CPU address 0 selects the data latch and address 1 selects the status/control byte. A read at address 0 returns the input latch. cpu_rdata is combinational from cpu_addr.
- R3: With mode 1, a rising edge of ext_wr_n while ext_cs_n is low captures ext_data_in into the input latch and sets input_full. The flag is visible three clock edges after the strobe rises.
- R4: A CPU read at address 0 clears input_full. An external write completing in the same cycle wins.
- R5: An external write that completes while input_full is 1 sets overflow, and the new byte replaces the old one in the input latch.
- R6: Overflow stays set through any other activity until the CPU writes the status byte with bit 5 at 0. A CPU write takes bit 5 as the new value.
- R7: A CPU write at address 0 loads the output latch and sets output_full. With mode 1, a rising edge of ext_rd_n while ext_cs_n is low clears output_full.
- R8: CPU writes to the status byte change only the overflow bit (bit 5), the mode bit (bit 4) and the direction bits (bits 2:0). Bits 7, 6 and 3 are unaffected.
- R9: ext_data_oe is 1 exactly when the mode is 1, ext_cs_n is 0 and ext_rd_n is 0. While it is 1, ext_data_out carries the output latch.
- R10: With mode 0, strobe activity captures nothing, changes no flag, raises no interrupt and never enables the bus drive.
- R11: With mode 1, strobe edges while ext_cs_n is high are ignored.
- R12: irq_pulse is high for exactly one cycle per completed external read or write in mode 1, in the same cycle as the flag update.
- R13: pin_dir outputs the three direction bits of the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| cpu_wr_en | input | 1 | CPU write strobe, one cycle |
| cpu_rd_en | input | 1 | CPU read strobe, one cycle, clears input_full at address 0 |
| cpu_addr | input | 1 | 0 = data latch, 1 = status/control |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_data_in | input | 8 | Byte driven by the external master |
| ext_data_out | output | 8 | Output latch toward the external bus |
| ext_data_oe | output | 1 | External data bus drive enable |
| pin_dir | output | 3 | Direction bits for the three control pins |
| irq_pulse | output | 1 | One-cycle transfer-complete pulse |

## Verification
The properties assume that external transfers are spaced apart. Two strobe completions never fall in adjacent cycles, and the master holds chip select and data steady for several clocks around each strobe edge. The interrupt-width and flag-origin checks depend on both conditions. The stimulus performs one transfer at a time, with chip select lowered two cycles before the strobe falls and raised only several cycles after it rises. CPU accesses happen only between external transfers, so simultaneous set and clear cases never reach the properties.

// File: rtl/psp_pkg.sv
package psp_pkg;
    localparam int PSP_DW   = 8;
    localparam int DIR_W    = 3;
    localparam int B_IBF    = 7;
    localparam int B_OBF    = 6;
    localparam int B_OVF    = 5;
    localparam int B_MODE   = 4;
    localparam int B_FIXED1 = 3;

    typedef struct packed {
        logic             in_full;
        logic             out_full;
        logic             ovf;
        logic             mode;
        logic [DIR_W-1:0] dir;
    } psp_ctl_t;

    typedef struct packed {
        logic wr_prev;
        logic rd_prev;
        logic wr_evt;
        logic rd_evt;
    } psp_front_t;

    typedef struct packed {
        psp_ctl_t          ctl;
        logic [PSP_DW-1:0] in_lat;
        logic [PSP_DW-1:0] out_lat;
        logic              irq;
    } psp_regs_t;

    function automatic logic [PSP_DW-1:0] status_byte(psp_ctl_t c);
        logic [PSP_DW-1:0] s;
        s = '0;
        s[B_IBF]      = c.in_full;
        s[B_OBF]      = c.out_full;
        s[B_OVF]      = c.ovf;
        s[B_MODE]     = c.mode;
        s[B_FIXED1]   = 1'b1;
        s[DIR_W-1:0]  = c.dir;
        return s;
    endfunction
endpackage

// File: rtl/psp_sync.sv
module psp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    // Idle level of the active-low pins is 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '1;
        end else begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= stage_d[k];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/psp_front.sv
module psp_front
    import psp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic cs_s,
    input  logic wr_s,
    input  logic rd_s,
    output logic wr_evt,
    output logic rd_evt
);
    psp_front_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.wr_prev = wr_s;
        st_d.rd_prev = rd_s;
        // Rising strobe edge, chip selected, port mode on.
        st_d.wr_evt  = 1'b0;
        st_d.rd_evt  = 1'b0;
        wr_evt = mode && !cs_s && wr_s && !st_q.wr_prev;
        rd_evt = mode && !cs_s && rd_s && !st_q.rd_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{wr_prev: 1'b1, rd_prev: 1'b1, wr_evt: 1'b0, rd_evt: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/psp_regs.sv
module psp_regs
    import psp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic              cpu_addr,
    input  logic [PSP_DW-1:0] cpu_wdata,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  logic [PSP_DW-1:0] ext_data_in,
    output psp_ctl_t          ctl,
    output logic [PSP_DW-1:0] in_lat,
    output logic [PSP_DW-1:0] out_lat,
    output logic              irq
);
    psp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        // Master side lowers output-full; a CPU load below wins.
        if (rd_evt) r_d.ctl.out_full = 1'b0;
        if (cpu_wr_en && cpu_addr) begin
            r_d.ctl.ovf  = cpu_wdata[B_OVF];
            r_d.ctl.mode = cpu_wdata[B_MODE];
            r_d.ctl.dir  = cpu_wdata[DIR_W-1:0];
        end
        if (cpu_wr_en && !cpu_addr) begin
            r_d.out_lat      = cpu_wdata;
            r_d.ctl.out_full = 1'b1;
        end
        if (cpu_rd_en && !cpu_addr) r_d.ctl.in_full = 1'b0;
        // Master write last so it wins over a same-cycle CPU read.
        if (wr_evt) begin
            r_d.in_lat      = ext_data_in;
            r_d.ctl.in_full = 1'b1;
            if (r_q.ctl.in_full) r_d.ctl.ovf = 1'b1;
        end
        r_d.irq = wr_evt || rd_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ctl: '{in_full: 1'b0, out_full: 1'b0, ovf: 1'b0, mode: 1'b0,
                            dir: '1},
                     in_lat: '0, out_lat: '0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl     = r_q.ctl;
    assign in_lat  = r_q.in_lat;
    assign out_lat = r_q.out_lat;
    assign irq     = r_q.irq;
endmodule

// File: rtl/psp_port.sv
module psp_port
    import psp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic              cpu_rd_en,
    input  logic              cpu_addr,
    input  logic [PSP_DW-1:0] cpu_wdata,
    output logic [PSP_DW-1:0] cpu_rdata,
    input  logic              ext_cs_n,
    input  logic              ext_wr_n,
    input  logic              ext_rd_n,
    input  logic [PSP_DW-1:0] ext_data_in,
    output logic [PSP_DW-1:0] ext_data_out,
    output logic              ext_data_oe,
    output logic [DIR_W-1:0]  pin_dir,
    output logic              irq_pulse
);
    logic [2:0]        pins_s;
    logic              wr_evt, rd_evt;
    psp_ctl_t          ctl;
    logic [PSP_DW-1:0] in_lat;
    logic [PSP_DW-1:0] out_lat;

    psp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ext_cs_n, ext_wr_n, ext_rd_n}),
        .sync_o  (pins_s)
    );

    psp_front u_front (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (ctl.mode),
        .cs_s   (pins_s[2]),
        .wr_s   (pins_s[1]),
        .rd_s   (pins_s[0]),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt)
    );

    psp_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_rd_en   (cpu_rd_en),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .wr_evt      (wr_evt),
        .rd_evt      (rd_evt),
        .ext_data_in (ext_data_in),
        .ctl         (ctl),
        .in_lat      (in_lat),
        .out_lat     (out_lat),
        .irq         (irq_pulse)
    );

    always_comb begin
        cpu_rdata    = cpu_addr ? status_byte(ctl) : in_lat;
        // Bus drive follows the raw pins for fast turn-on.
        ext_data_oe  = ctl.mode && !ext_cs_n && !ext_rd_n;
        ext_data_out = out_lat;
        pin_dir      = ctl.dir;
    end
endmodule

// File: rtl/psp_port_chk.sv
module psp_port_chk
    import psp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr_en,
    input logic              cpu_rd_en,
    input logic              cpu_addr,
    input logic [PSP_DW-1:0] cpu_wdata,
    input logic              ext_cs_n,
    input logic              ext_rd_n,
    input logic              ext_data_oe,
    input logic              irq_pulse,
    input psp_ctl_t          st
);
    a_r9_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ext_data_oe |-> (st.mode && !ext_cs_n && !ext_rd_n));

    a_r3_in_full_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.in_full) |-> $past(st.mode));

    a_r4_in_full_cpu_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st.in_full) |-> $past(cpu_rd_en && !cpu_addr));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st.ovf) |-> $past(cpu_wr_en && cpu_addr && !cpu_wdata[B_OVF]));

    a_r7_out_full_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr_en && !cpu_addr) |=> st.out_full);

    a_r7_out_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st.out_full) |-> $past(st.mode));

    a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r10_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(st.mode));
endmodule

bind psp_port psp_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr_en   (cpu_wr_en),
    .cpu_rd_en   (cpu_rd_en),
    .cpu_addr    (cpu_addr),
    .cpu_wdata   (cpu_wdata),
    .ext_cs_n    (ext_cs_n),
    .ext_rd_n    (ext_rd_n),
    .ext_data_oe (ext_data_oe),
    .irq_pulse   (irq_pulse),
    .st          (ctl)
);

// File: tb/psp_port_tb.sv
module psp_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr_en = 1'b0, cpu_rd_en = 1'b0, cpu_addr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ext_cs_n = 1'b1, ext_wr_n = 1'b1, ext_rd_n = 1'b1;
    logic [7:0] ext_data_in = '0;
    logic [7:0] ext_data_out;
    logic       ext_data_oe;
    logic [2:0] pin_dir;
    logic       irq_pulse;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;

    psp_port u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ext_cs_n(ext_cs_n), .ext_wr_n(ext_wr_n), .ext_rd_n(ext_rd_n),
        .ext_data_in(ext_data_in), .ext_data_out(ext_data_out),
        .ext_data_oe(ext_data_oe), .pin_dir(pin_dir), .irq_pulse(irq_pulse)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) if (rst_n && irq_pulse) irq_cnt <= irq_cnt + 1;

    localparam logic [2:0] OP_CW_CTL = 3'd0, OP_CW_DAT = 3'd1, OP_CR_DAT = 3'd2,
                           OP_EW = 3'd3, OP_ER = 3'd4;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] arg;
        logic [7:0] stat;
        logic [7:0] dat;
        logic       irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{OP_CW_CTL, 8'h17, 8'h1F, 8'h00, 1'b0},
        '{OP_EW,     8'hA5, 8'h9F, 8'h00, 1'b1},
        '{OP_CR_DAT, 8'h00, 8'h1F, 8'hA5, 1'b0},
        '{OP_EW,     8'h11, 8'h9F, 8'h00, 1'b1},
        '{OP_EW,     8'h22, 8'hBF, 8'h00, 1'b1},
        '{OP_CR_DAT, 8'h00, 8'h3F, 8'h22, 1'b0},
        '{OP_CW_CTL, 8'h37, 8'h3F, 8'h00, 1'b0},
        '{OP_CW_CTL, 8'h17, 8'h1F, 8'h00, 1'b0},
        '{OP_CW_DAT, 8'h5A, 8'h5F, 8'h00, 1'b0},
        '{OP_ER,     8'h00, 8'h1F, 8'h5A, 1'b1},
        '{OP_CW_CTL, 8'h12, 8'h1A, 8'h00, 1'b0},
        '{OP_CW_CTL, 8'h07, 8'h0F, 8'h00, 1'b0},
        '{OP_EW,     8'h99, 8'h0F, 8'h00, 1'b0},
        '{OP_CR_DAT, 8'h00, 8'h0F, 8'h22, 1'b0},
        '{OP_CW_DAT, 8'h33, 8'h4F, 8'h00, 1'b0},
        '{OP_ER,     8'h00, 8'h4F, 8'h00, 1'b0},
        '{OP_CW_CTL, 8'hF7, 8'h7F, 8'h00, 1'b0},
        '{OP_ER,     8'h00, 8'h3F, 8'h33, 1'b1}
    };

    function automatic string tag_of(vec_t v);
        case (v.op)
            OP_EW:     return !v.irq ? "R10" : (v.stat[5] ? "R5" : "R3");
            OP_ER:     return !v.irq ? "R10" : "R7";
            OP_CR_DAT: return "R4";
            OP_CW_DAT: return "R7";
            default:   return "R8";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(logic a, logic [7:0] d);
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr_en = 1'b0;
    endtask

    task automatic cpu_read(logic a, output logic [7:0] d);
        @(negedge clk);
        cpu_rd_en = 1'b1; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd_en = 1'b0;
    endtask

    task automatic ext_write(logic [7:0] d, logic use_cs);
        @(negedge clk);
        ext_cs_n = !use_cs; ext_data_in = d;
        repeat (2) @(negedge clk);
        ext_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        ext_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ext_read(output logic oe_seen, output logic [7:0] d);
        @(negedge clk);
        ext_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_rd_n = 1'b0;
        #1 oe_seen = ext_data_oe; d = ext_data_out;
        repeat (3) @(negedge clk);
        ext_rd_n = 1'b1;
        repeat (4) @(negedge clk);
        ext_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        int         irq0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value of status byte and outputs
        cpu_read(1'b1, rd);
        check("R1", rd, 8'h0F);
        check("R13", {5'd0, pin_dir}, 8'h07);
        check("R1", {7'd0, irq_pulse}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            irq0 = irq_cnt;
            case (VEC[i].op)
                OP_CW_CTL: cpu_write(1'b1, VEC[i].arg);
                OP_CW_DAT: cpu_write(1'b0, VEC[i].arg);
                OP_CR_DAT: begin
                    cpu_read(1'b0, rd);
                    check("R2", rd, VEC[i].dat);
                end
                OP_EW: ext_write(VEC[i].arg, 1'b1);
                OP_ER: begin
                    ext_read(oe, rd);
                    check("R9", {7'd0, oe}, {7'd0, VEC[i].irq});
                    if (VEC[i].irq) check("R9", rd, VEC[i].dat);
                end
                default: ;
            endcase
            if (VEC[i].op == OP_EW || VEC[i].op == OP_ER)
                check("R12", 8'(irq_cnt - irq0), {7'd0, VEC[i].irq});
            cpu_read(1'b1, rd);
            check(tag_of(VEC[i]), rd, VEC[i].stat);
            check("R13", {5'd0, pin_dir}, {5'd0, VEC[i].stat[2:0]});
        end

        // R6 overflow survives a data read and strobe traffic
        cpu_read(1'b0, rd);
        ext_read(oe, rd);
        cpu_read(1'b1, rd);
        check("R6", rd, 8'h3F);
        cpu_write(1'b1, 8'h17);
        cpu_read(1'b1, rd);
        check("R6", rd, 8'h1F);

        // R11 write strobe without chip select
        irq0 = irq_cnt;
        ext_write(8'hC3, 1'b0);
        cpu_read(1'b1, rd);
        check("R11", rd, 8'h1F);
        check("R11", 8'(irq_cnt - irq0), 8'h00);
        cpu_read(1'b0, rd);
        check("R11", rd, 8'h22);

        // R9 drive enable needs both pins low
        @(negedge clk);
        ext_cs_n = 1'b0; ext_rd_n = 1'b1;
        #1 check("R9", {7'd0, ext_data_oe}, 8'h00);
        @(negedge clk);
        ext_cs_n = 1'b1; ext_rd_n = 1'b0;
        #1 check("R9", {7'd0, ext_data_oe}, 8'h00);
        @(negedge clk);
        ext_rd_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset mid-run restores defaults
        cpu_write(1'b0, 8'h44);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        cpu_read(1'b1, rd);
        check("R1", rd, 8'h0F);

        finish_run();
    end
endmodule